// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and a 32K x 8 asynchronous static RAM. It accepts one single-byte read or write at a time through a valid/ready handshake and turns it into a sequence of the three active-low RAM strobes: chip select, output enable and write strobe. It also drives a 15-bit address bus and a split data path that a pad ring merges into one bidirectional bus. The data path has an outgoing byte, a drive-enable and an incoming byte.

Every RAM timing limit is a parameter in nanoseconds, and so is the clock period, given in picoseconds. Each limit is rounded up to a whole number of clock cycles when the block is built. A read keeps chip select and output enable low for the access count and then registers the incoming byte, and a one-cycle strobe announces it. A write first drives the data with the write strobe still high. It then pulses the write strobe low for the pulse count and lowers output enable at no point. Every access ends with a recovery interval with the chip deselected, and only after it is a new request accepted.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is 1, `ram_cs_n`, `ram_oe_n` and `ram_wr_n` are all 1 and `ram_dq_oe` is 0. `req_ready` is 1 after reset.
- R2: An accepted read (`req_we`=0) holds `ram_cs_n`=0, `ram_oe_n`=0 and `ram_wr_n`=1 with `ram_addr` equal to the request address for exactly ACC cycles. `rd_valid` is 1 for exactly one cycle after that, with `rd_data` equal to the byte on `ram_dq_in` at the end of the access.
- R3: `ram_dq_oe` is never 1 while `ram_oe_n` is 0. `ram_oe_n` is 1 for the whole of every write. `ram_dq_oe` only turns on after a cycle with `ram_oe_n` at 1.
- R4: An accepted write (`req_we`=1) spends one cycle with `ram_cs_n`=0, `ram_wr_n`=1 and the data driven, then WP cycles with `ram_wr_n`=0. During the whole write `ram_addr` and `ram_dq_out` hold the request values. `ram_wr_n`, `ram_cs_n` and `ram_dq_oe` all release on the same edge.
- R5: After every access, `ram_cs_n` is 1 and `req_ready` is 0 for REC cycles before `req_ready` returns to 1.
- R6: Changes to `req_addr`, `req_wdata` and `req_we` after acceptance have no effect on the RAM pins of the access in progress.
- R7: ACC = max(ceil(t_access/T), ceil(t_cycle/T)), WP = max(ceil(t_pulse/T), ceil(t_datasetup/T), ceil(t_addrvalid/T), ceil(t_cycle/T)-1) and REC = ceil(t_release/T), each at least 1. At the defaults (T=10 ns) ACC=2, WP=1 and REC=1.
- R8: `rd_valid` never pulses for a write.
- R9: A location that is read back returns the last byte written to it, including at address 0 and at the top address 0x7FFF, across write-then-read and read-then-write orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` holds a new read result |
| rd_data | output | 8 | Last captured read byte |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| ram_addr | output | 15 | RAM address bus |
| ram_dq_out | output | 8 | Byte driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | 8 | Byte coming from the RAM |

## Verification
The main function is exercised with reads of a location that was never written (its content comes from a preset pattern), so that the captured byte must come from the bus sample and not from a stale write register. Writes followed by reads at the low address, a mid address and the top address show that address bits reach the pins intact. An overwrite followed by a read tells a real write pulse apart from one that never reaches the model RAM. During every access the request fields are changed to their complements, which separates fields sampled at acceptance from fields that pass straight through. Strobe durations are counted against the bench's own rounding of the nanosecond limits.

// File: rtl/sram_seq_pkg.sv
// Shared types and cycle-count helpers for the SRAM access sequencer.
// Assumes all timing limits are non-negative nanosecond integers and the
// clock period is a positive picosecond integer.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WSET = 3'd2,
        ST_WPUL = 3'd3,
        ST_REC  = 3'd4
    } seq_state_t;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int lim_ns, input int clk_ps);
        int c;
        c = (lim_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down counter that times the length of each sequencer phase.
// Loading N makes done rise N cycles later; load has priority over counting.
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: idle, read access, write setup, write pulse, recovery.
// Assumes the timer's done reflects a count loaded on the phase entry edge.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int ACC_CYC = 2,
    parameter int WP_CYC  = 1,
    parameter int REC_CYC = 1,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             acc_we,
    input  logic             tmr_done,
    output seq_state_t       state_q,
    output seq_state_t       state_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture
);

    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    // Choose the next phase and the length to load into the timer.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d  = acc_we ? ST_WSET : ST_RD;
                tmr_load = 1'b1;
                tmr_val  = acc_we ? '0 : ACC_LD;
            end
            ST_RD: if (tmr_done) begin
                state_d  = ST_REC;
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = REC_LD;
            end
            ST_WSET: begin
                state_d  = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WPUL: if (tmr_done) begin
                state_d  = ST_REC;
                tmr_load = 1'b1;
                tmr_val  = REC_LD;
            end
            ST_REC: if (tmr_done) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/sram_pin_drv.sv
// Registered RAM pin driver and read capture. Strobes are decoded from the
// next phase and flopped, so pins change only on clock edges and never glitch.
// Address and write byte are held from acceptance until the next request.
module sram_pin_drv
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              cs_n,
    output logic              oe_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Strobes and drive enable follow the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            wr_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= !(state_d inside {ST_RD, ST_WSET, ST_WPUL});
            oe_n  <= (state_d != ST_RD);
            wr_n  <= (state_d != ST_WPUL);
            dq_oe <= (state_d inside {ST_WSET, ST_WPUL});
        end
    end

    // Request fields are sampled once, at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            dq_out <= '0;
        end else if (accept) begin
            addr   <= acc_addr;
            dq_out <= acc_wdata;
        end
    end

    // Read byte capture and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
// Top of the asynchronous SRAM access sequencer. Converts one valid/ready
// request at a time into chip-select / output-enable / write-strobe phases
// whose lengths are nanosecond limits rounded up to clock cycles.
// Assumes the RAM data lines are merged from dq_out/dq_oe/dq_in at the pads.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CLK_PS    = 10000,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int T_ACC_NS  = 12,
    parameter int T_CYC_NS  = 12,
    parameter int T_WP_NS   = 8,
    parameter int T_DS_NS   = 8,
    parameter int T_AV_NS   = 10,
    parameter int T_REL_NS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_wr_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int ACC_CYC = imax(ns_to_cyc(T_ACC_NS, CLK_PS), ns_to_cyc(T_CYC_NS, CLK_PS));
    localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_DS_NS, CLK_PS)),
                                  imax(ns_to_cyc(T_AV_NS, CLK_PS), ns_to_cyc(T_CYC_NS, CLK_PS) - 1));
    localparam int REC_CYC = ns_to_cyc(T_REL_NS, CLK_PS);
    localparam int MAX_CYC = imax(imax(ACC_CYC, WP_CYC), REC_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             capture;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_seq_fsm #(
        .ACC_CYC (ACC_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .acc_we   (req_we),
        .tmr_done (tmr_done),
        .state_q  (state_q),
        .state_d  (state_d),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .capture  (capture)
    );

    sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .accept    (accept),
        .acc_addr  (req_addr),
        .acc_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (ram_dq_in),
        .cs_n      (ram_cs_n),
        .oe_n      (ram_oe_n),
        .wr_n      (ram_wr_n),
        .addr      (ram_addr),
        .dq_out    (ram_dq_out),
        .dq_oe     (ram_dq_oe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/sram_seq_chk.sv
// Protocol checker for the SRAM access sequencer, observing only top ports.
// Assumes a synchronous active-low reset held for at least one edge.
module sram_seq_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              ram_cs_n,
    input logic              ram_oe_n,
    input logic              ram_wr_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe
);

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && ram_oe_n && ram_wr_n && !ram_dq_oe));

    // R3
    oe_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> !ram_dq_oe);

    // R3
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n |-> (ram_oe_n && !ram_cs_n && ram_dq_oe));

    // R3
    drive_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> $past(ram_oe_n));

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_wr_n && !$past(ram_wr_n)) |-> ($stable(ram_addr) && $stable(ram_dq_out)));

    // R4
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_n) |-> (ram_cs_n && !ram_dq_oe));

    // R2
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    rdv_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!$past(ram_oe_n) && ram_cs_n));

    // R5
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(ram_cs_n));

endmodule

bind sram_seq_ctrl sram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .ram_cs_n   (ram_cs_n),
    .ram_oe_n   (ram_oe_n),
    .ram_wr_n   (ram_wr_n),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_seq_ctrl_test.sv
// Directed bench for the SRAM access sequencer with a small behavioural RAM.
module sram_seq_ctrl_test;

    localparam int CLK_PS = 10000;
    // Bench's own rounding of the nanosecond limits (R7).
    localparam int ACC = 2;
    localparam int WP  = 1;
    localparam int REC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe;
    logic [14:0] ram_addr;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:255];

    always #5ns clk = ~clk;

    sram_seq_ctrl #(.CLK_PS(CLK_PS)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_wr_n(ram_wr_n),
        .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    // RAM model: stores while select and write strobe overlap, drives on read.
    always @(negedge clk) begin
        if (!ram_cs_n && !ram_wr_n) mem[ram_addr[7:0]] <= ram_dq_out;
    end
    assign ram_dq_in = (!ram_cs_n && !ram_oe_n && ram_wr_n) ? mem[ram_addr[7:0]] : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_idle(input string tag);
        chk(req_ready == 1'b1, {tag, " ready"}, req_ready, 1);
        chk({ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe} == 4'b1110, {tag, " pins"},
            {ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe}, 4'b1110);
    endtask

    task automatic recovery(input string tag);
        for (int i = 1; i < REC; i++) begin
            @(negedge clk);
            chk(req_ready == 1'b0 && ram_cs_n, {tag, " R5 recover"}, req_ready, 0);
        end
        @(negedge clk);
        chk(rd_valid == 1'b0, {tag, " R2 rd_valid one cycle"}, rd_valid, 0);
        expect_idle({tag, " R5 R1 back to idle"});
    endtask

    task automatic do_read(input logic [14:0] a, input logic [7:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_we = 1'b1; req_wdata = 8'hFF;
        for (int i = 0; i < ACC; i++) begin
            chk({ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe} == 4'b0010, "R2 R3 read strobes",
                {ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe}, 4'b0010);
            chk(ram_addr == a, "R6 read address held", ram_addr, a);
            chk(rd_valid == 1'b0, "R2 no early rd_valid", rd_valid, 0);
            if (i < ACC - 1) @(negedge clk);
        end
        @(negedge clk);
        chk(ram_oe_n && ram_cs_n, "R7 access length", {ram_cs_n, ram_oe_n}, 2'b11);
        chk(rd_valid == 1'b1, "R2 rd_valid", rd_valid, 1);
        chk(rd_data == exp, "R2 R9 read data", rd_data, exp);
        chk(req_ready == 1'b0, "R5 busy in recovery", req_ready, 0);
        recovery("read");
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_we = 1'b0;
        chk({ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe} == 4'b0111, "R4 write setup",
            {ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe}, 4'b0111);
        for (int i = 0; i < WP; i++) begin
            @(negedge clk);
            chk({ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe} == 4'b0101, "R3 R4 write pulse",
                {ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe}, 4'b0101);
            chk(ram_addr == a, "R6 write address held", ram_addr, a);
            chk(ram_dq_out == d, "R6 write data held", ram_dq_out, d);
        end
        @(negedge clk);
        chk({ram_cs_n, ram_wr_n, ram_dq_oe} == 3'b110, "R4 R7 joint release",
            {ram_cs_n, ram_wr_n, ram_dq_oe}, 3'b110);
        chk(rd_valid == 1'b0, "R8 no rd_valid on write", rd_valid, 0);
        chk(req_ready == 1'b0, "R5 busy in recovery", req_ready, 0);
        recovery("write");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10ns);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        chk(ram_cs_n && ram_oe_n && ram_wr_n && !ram_dq_oe, "R1 pins in reset",
            {ram_cs_n, ram_oe_n, ram_wr_n, ram_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1 after reset");
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);

        do_read(15'h0011, 8'h11 ^ 8'h5A);   // R2 unwritten location
        do_write(15'h1234, 8'h3C);          // R4
        do_read(15'h1234, 8'h3C);           // R9 write then read
        do_write(15'h7FFF, 8'hC3);          // R9 top address
        do_write(15'h0000, 8'h00);          // R9 address zero
        do_read(15'h7FFF, 8'hC3);
        do_read(15'h0000, 8'h00);
        do_write(15'h1234, 8'hA7);          // R9 overwrite after read
        do_read(15'h1234, 8'hA7);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule